// File: doc/BRIEF.md
# Swizzling Co-issue Vector ALU

A four-lane arithmetic unit for shader-style pixel and vertex work. Each instruction carries two four-component source vectors plus an addend vector. Every lane of the two sources passes through its own component selector first, so any component can feed any lane. After that, each lane runs its own opcode. A single instruction can therefore split the lanes 3+1, 2+2 or in any other pattern and issue several different operations in the same cycle.

Conditional code is handled by predication, not by branching. A compare opcode sets a one-bit per-object flag. Later instructions can be marked to commit only when that flag is true, or only when it is false. When the mark does not match, the instruction still flows through the unit but its per-lane write enables stay low. The result, the per-lane write enables and a valid strobe appear one clock after each accepted instruction.

Top module: `swizzle_coissue_alu`

## Requirements
- R1: During and right after reset, `out_valid`, `lane_we`, `result` and `pred_flag` are all zero.
- R2: `out_valid` is high exactly one cycle after each cycle with `in_valid` high, and low otherwise.
- R3: Lane l of `src_a`, `src_b` and `src_c` occupies bits [16l+15:16l], with lane 0 = R, 1 = G, 2 = B, 3 = A. Lane l of `swz_a` and `swz_b` occupies bits [2l+1:2l] and picks the operand component fed to lane l (00=R, 01=G, 10=B, 11=A). `src_c` is used without reordering.
- R4: Opcode 1 gives a+b and opcode 2 gives a-b, both 16-bit two's complement with wraparound.
- R5: Opcode 3 gives the low 16 bits of a*b, and opcode 4 gives the low 16 bits of a*b+c.
- R6: Opcode 0 passes the selected first operand a through unchanged.
- R7: The opcode of lane l sits in `lane_op` bits [3l+2:3l]. All four lanes run their own opcodes in the same cycle, independently of each other.
- R8: Opcode 5 compares a > b as signed values. A valid instruction with at least one opcode-5 lane sets `pred_flag` to the OR of those comparisons. That flag is visible from the cycle after. An opcode-5 lane produces a result of 0 and no write enable.
- R9: `pred_mode` 00 commits always, 01 commits only if the flag held before this instruction is 1, 10 commits only if it is 0, and 11 never commits.
- R10: `lane_we` is the AND of the commit decision, `wmask` and "lane opcode is 0 to 4". Opcodes 6 and 7 give result 0 and no write enable.
- R11: A cycle with `in_valid` low leaves `result` and `pred_flag` unchanged and drives `lane_we` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| src_a | input | 64 | First source vector |
| src_b | input | 64 | Second source vector |
| src_c | input | 64 | Addend vector for multiply-add |
| swz_a | input | 8 | Component selectors for the first source |
| swz_b | input | 8 | Component selectors for the second source |
| lane_op | input | 12 | Per-lane opcodes |
| wmask | input | 4 | Per-lane write mask |
| pred_mode | input | 2 | Predicate commit condition |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result vector |
| lane_we | output | 4 | Per-lane committed write enables |
| pred_flag | output | 1 | Current predicate flag |

## Verification
The bench builds the block with its defaults: four lanes, 16-bit data and 3-bit opcodes. This makes all 256 selector patterns per operand reachable. It also lets directed values reach signed overflow at the 16-bit edges. Random stimulus mixes every opcode across lanes, including the two reserved codes, so that 3+1, 2+2 and arbitrary groupings all occur. The random runs also interleave compares with if-true and if-false instructions, so both predicate states and the never-commit mode are covered.

// File: rtl/salu_pkg.sv
`timescale 1ns/1ps
package salu_pkg;
  typedef enum logic [2:0] {
    OPC_MOV = 3'd0,
    OPC_ADD = 3'd1,
    OPC_SUB = 3'd2,
    OPC_MUL = 3'd3,
    OPC_MAD = 3'd4,
    OPC_GT  = 3'd5
  } opc_e;

  typedef enum logic [1:0] {
    PM_ALWAYS = 2'b00,
    PM_IFTRUE = 2'b01,
    PM_IFFALSE = 2'b10,
    PM_NEVER = 2'b11
  } pmode_e;

  function automatic logic pred_allows(logic [1:0] mode, logic flag);
    case (mode)
      PM_ALWAYS:  return 1'b1;
      PM_IFTRUE:  return flag;
      PM_IFFALSE: return !flag;
      default:    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/salu_swizzle.sv
`timescale 1ns/1ps
module salu_swizzle #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  localparam int SEL_W = $clog2(LANES),
  localparam int VEC_W = LANES * DATA_W
) (
  input  logic [VEC_W-1:0]       src,
  input  logic [LANES*SEL_W-1:0] sel,
  output logic [VEC_W-1:0]       dst
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SEL_W-1:0] pick;
    assign pick = sel[l*SEL_W +: SEL_W];
    assign dst[l*DATA_W +: DATA_W] = src[pick*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/salu_lanes.sv
`timescale 1ns/1ps
module salu_lanes #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int OP_W   = 3,
  localparam int VEC_W = LANES * DATA_W
) (
  input  logic [VEC_W-1:0]      opa,
  input  logic [VEC_W-1:0]      opb,
  input  logic [VEC_W-1:0]      opc,
  input  logic [LANES*OP_W-1:0] ops,
  output logic [VEC_W-1:0]      res,
  output logic [LANES-1:0]      is_cmp,
  output logic [LANES-1:0]      cmp_gt,
  output logic [LANES-1:0]      writes_data
);
  import salu_pkg::*;

  function automatic logic [DATA_W-1:0] lane_math(
    logic [OP_W-1:0] op, logic [DATA_W-1:0] a, logic [DATA_W-1:0] b, logic [DATA_W-1:0] c);
    logic [DATA_W-1:0] r;
    case (op)
      OP_W'(OPC_MOV): r = a;
      OP_W'(OPC_ADD): r = a + b;
      OP_W'(OPC_SUB): r = a - b;
      OP_W'(OPC_MUL): r = a * b;
      OP_W'(OPC_MAD): r = a * b + c;
      default:        r = '0;
    endcase
    return r;
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [OP_W-1:0]   op;
    logic [DATA_W-1:0] a, b, c;
    assign op = ops[l*OP_W +: OP_W];
    assign a  = opa[l*DATA_W +: DATA_W];
    assign b  = opb[l*DATA_W +: DATA_W];
    assign c  = opc[l*DATA_W +: DATA_W];
    assign res[l*DATA_W +: DATA_W] = lane_math(op, a, b, c);
    assign is_cmp[l]      = (op == OP_W'(OPC_GT));
    assign cmp_gt[l]      = $signed(a) > $signed(b);
    assign writes_data[l] = (op <= OP_W'(OPC_MAD));
  end
endmodule

// File: rtl/salu_pred.sv
`timescale 1ns/1ps
module salu_pred (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic nxt,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (upd) flag <= nxt;
  end

  // R8: flag moves only on a compare-carrying instruction
  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flag));
  a_r8_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flag == $past(nxt));
endmodule

// File: rtl/swizzle_coissue_alu.sv
`timescale 1ns/1ps
module swizzle_coissue_alu #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int OP_W   = 3,
  localparam int SEL_W = $clog2(LANES),
  localparam int VEC_W = LANES * DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [VEC_W-1:0]       src_a,
  input  logic [VEC_W-1:0]       src_b,
  input  logic [VEC_W-1:0]       src_c,
  input  logic [LANES*SEL_W-1:0] swz_a,
  input  logic [LANES*SEL_W-1:0] swz_b,
  input  logic [LANES*OP_W-1:0]  lane_op,
  input  logic [LANES-1:0]       wmask,
  input  logic [1:0]             pred_mode,
  output logic                   out_valid,
  output logic [VEC_W-1:0]       result,
  output logic [LANES-1:0]       lane_we,
  output logic                   pred_flag
);
  import salu_pkg::*;

  logic [VEC_W-1:0] opa, opb, lane_res;
  logic [LANES-1:0] is_cmp, cmp_gt, writes_data;
  logic             pred_pass;
  logic             cmp_issue;
  logic [LANES-1:0] we_next;

  salu_swizzle #(.LANES(LANES), .DATA_W(DATA_W)) u_swz_a (
    .src(src_a), .sel(swz_a), .dst(opa));
  salu_swizzle #(.LANES(LANES), .DATA_W(DATA_W)) u_swz_b (
    .src(src_b), .sel(swz_b), .dst(opb));

  salu_lanes #(.LANES(LANES), .DATA_W(DATA_W), .OP_W(OP_W)) u_lanes (
    .opa(opa), .opb(opb), .opc(src_c), .ops(lane_op),
    .res(lane_res), .is_cmp(is_cmp), .cmp_gt(cmp_gt), .writes_data(writes_data));

  assign pred_pass = pred_allows(pred_mode, pred_flag);
  assign cmp_issue = in_valid && (|is_cmp);
  assign we_next   = wmask & writes_data & {LANES{pred_pass}};

  salu_pred u_pred (
    .clk(clk), .rst_n(rst_n), .upd(cmp_issue), .nxt(|(is_cmp & cmp_gt)), .flag(pred_flag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      lane_we   <= '0;
    end else begin
      out_valid <= in_valid;
      lane_we   <= in_valid ? we_next : '0;
      if (in_valid) result <= lane_res;
    end
  end

  // R2: one-cycle valid latency
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R11: idle cycle holds result and commits nothing
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && lane_we == '0));
  // R10: enables never escape the mask
  a_r10_we_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (lane_we & ~$past(wmask)) == '0);
  // R9: never-commit mode writes nothing
  a_r9_never_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_mode == 2'b11) |=> lane_we == '0);
  // R8: compare lanes write nothing
  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (lane_we & $past(is_cmp)) == '0);
endmodule

// File: tb/swizzle_coissue_alu_tb.sv
`timescale 1ns/1ps
module swizzle_coissue_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] src_a = '0, src_b = '0, src_c = '0;
  logic [7:0]  swz_a = 8'hE4, swz_b = 8'hE4;
  logic [11:0] lane_op = '0;
  logic [3:0]  wmask = '0;
  logic [1:0]  pred_mode = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [3:0]  lane_we;
  logic        pred_flag;

  int checks = 0, errors = 0;
  logic        m_flag = 1'b0;
  logic [63:0] m_res = '0;

  always #4 clk = ~clk;

  swizzle_coissue_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .src_c(src_c), .swz_a(swz_a), .swz_b(swz_b), .lane_op(lane_op), .wmask(wmask),
    .pred_mode(pred_mode), .out_valid(out_valid), .result(result), .lane_we(lane_we),
    .pred_flag(pred_flag));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pick(logic [63:0] v, logic [7:0] s, int l);
    int idx = int'(s[2*l +: 2]);
    return v[16*idx +: 16];
  endfunction

  function automatic logic [15:0] calc(logic [2:0] op, logic [15:0] a, logic [15:0] b, logic [15:0] c);
    int sa = int'($signed(a)), sb = int'($signed(b)), sc = int'($signed(c));
    int r;
    case (op)
      3'd0: r = sa;
      3'd1: r = sa + sb;
      3'd2: r = sa - sb;
      3'd3: r = sa * sb;
      3'd4: r = sa * sb + sc;
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  // drive one cycle, compare against bench model after the edge
  task automatic step(string tag);
    logic [63:0] e_res;
    logic [3:0]  e_we;
    logic        pass, any_cmp, gt_or;
    @(negedge clk);
    e_res = m_res; e_we = '0; any_cmp = 0; gt_or = 0;
    case (pred_mode)
      2'b00: pass = 1; 2'b01: pass = m_flag; 2'b10: pass = !m_flag; default: pass = 0;
    endcase
    if (in_valid) begin
      for (int l = 0; l < 4; l++) begin
        logic [2:0] op = lane_op[3*l +: 3];
        logic [15:0] a = pick(src_a, swz_a, l), b = pick(src_b, swz_b, l);
        e_res[16*l +: 16] = calc(op, a, b, src_c[16*l +: 16]);
        e_we[l] = pass && wmask[l] && (op < 3'd5);
        if (op == 3'd5) begin
          any_cmp = 1;
          if ($signed(a) > $signed(b)) gt_or = 1;
        end
      end
    end
    @(posedge clk); #1;
    if (in_valid && any_cmp) m_flag = gt_or;
    m_res = e_res;
    check({tag, " R2 valid"}, {63'd0, out_valid}, {63'd0, in_valid});
    check({tag, " result"}, result, e_res);
    check({tag, " R10 we"}, {60'd0, lane_we}, {60'd0, e_we});
    check({tag, " R8 flag"}, {63'd0, pred_flag}, {63'd0, m_flag});
  endtask

  function automatic logic [63:0] v4(int r, int g, int b, int a);
    return {16'(a), 16'(b), 16'(g), 16'(r)};
  endfunction

  task automatic setop(logic [2:0] r, logic [2:0] g, logic [2:0] b, logic [2:0] a);
    lane_op = {a, b, g, r};
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 result", result, 64'd0);
    check("R1 lane_we", {60'd0, lane_we}, 64'd0);
    check("R1 pred_flag", {63'd0, pred_flag}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R3 R6: swizzle through MOV, lane R reads G
    in_valid = 1; wmask = 4'hF; pred_mode = 2'b00;
    src_a = v4(10, 20, 30, 40); swz_a = 8'b11_10_01_01; setop(0, 0, 0, 0);
    step("R3 R6 mov-swizzle");
    // R3: result R = a.R + b.G
    src_b = v4(100, 7, 100, 0); swz_a = 8'hE4; swz_b = 8'b11_10_01_01; setop(1, 1, 1, 1);
    step("R3 cross-add");
    // R3: full reversal and broadcast
    swz_a = 8'b00_01_10_11; swz_b = 8'b11_11_11_11; step("R3 reverse");
    // R4 wraparound
    swz_a = 8'hE4; swz_b = 8'hE4;
    src_a = v4(32767, -32768, 5, 0); src_b = v4(1, 1, 9, 0); setop(1, 2, 2, 1);
    step("R4 wrap");
    // R5 multiply and multiply-add wrap
    src_a = v4(300, 300, -7, 3); src_b = v4(300, 300, 6, 4); src_c = v4(0, 5, 2, -12);
    setop(3, 4, 4, 3); step("R5 mul-mad");
    // R7 3+1 and 2+2 groupings
    setop(1, 1, 1, 3); step("R7 three-plus-one");
    setop(1, 1, 3, 3); step("R7 two-plus-two");
    setop(2, 4, 0, 1); step("R7 arbitrary");
    // R8 R9 predicate
    src_a = v4(5, 0, 0, 0); src_b = v4(1, 0, 0, 0); setop(5, 7, 7, 7); step("R8 gt-true");
    setop(1, 1, 1, 1); pred_mode = 2'b01; step("R9 if-true");
    pred_mode = 2'b10; step("R9 if-false");
    src_a = v4(-3, 0, 0, 0); setop(5, 6, 6, 6); pred_mode = 2'b00; step("R8 gt-false");
    setop(1, 1, 1, 1); pred_mode = 2'b10; step("R9 if-false");
    pred_mode = 2'b11; step("R9 never");
    // R10 mask and reserved codes
    pred_mode = 2'b00; wmask = 4'b0101; setop(6, 1, 7, 0); step("R10 mask-reserved");
    // R11 idle
    in_valid = 0; src_a = v4(1, 2, 3, 4); setop(1, 1, 5, 1); step("R11 idle");
    step("R11 idle2");

    for (int i = 0; i < 600; i++) begin
      in_valid = ($urandom % 5) != 0;
      src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom}; src_c = {$urandom, $urandom};
      if (i % 7 == 0) src_a[15:0] = src_b[15:0];
      swz_a = 8'($urandom); swz_b = 8'($urandom);
      lane_op = 12'($urandom); wmask = 4'($urandom); pred_mode = 2'($urandom);
      step("R7 R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule